// File: doc/BRIEF.md
# Cache-Line Next-Line Branch Predictor

This block holds one branch prediction per instruction-cache line for a fetch unit. Each entry holds three things: the byte offset at which the fetch window of that line is expected to end, a one-bit taken flag, and the cache index of the line predicted to follow it. A fetch lookup presents a line index. One cycle later the block returns the window end offset, the taken flag and the next line index. The next line index is either the stored successor or, for a not-taken line, the sequential line.

When a branch resolves as mispredicted, the resolution port rewrites the entry of its line. The rewrite happens only when the branch came from a cacheable fetch. The mispredict also opens a short redirect window, and lookups made during that window are returned without a valid flag. A global invalidate drops every prediction at once. Lookups served from the prefetch path ignore the stored entry and are always predicted not-taken.

Top module: `line_next_predictor`

## Requirements
- R1: A line that has no prediction (after reset or after an invalidate) reads as not-taken, with end offset 15 and next index equal to the looked-up index plus one, wrapping from LINES-1 to 0.
- R2: After a cacheable update with taken flag 1, a lookup of that line returns taken 1, the stored end offset and the stored successor index.
- R3: The latest update of a line replaces its entry completely (a 1-bit scheme). A line whose entry says not-taken reads end offset 15 and the sequential next index.
- R4: An update whose cacheable flag is 0 leaves the entry unchanged.
- R5: A lookup flagged as coming from the prefetch path returns not-taken, end offset 15 and the sequential next index, whatever the entry holds.
- R6: When an update and a lookup name the same line in the same cycle, the lookup returns the old entry. The new entry is returned from the next cycle on.
- R7: An invalidate clears every entry in one cycle. An update presented in the same cycle as an invalidate writes nothing.
- R8: A lookup presented in the same cycle as an update, or in either of the two cycles that follow it, returns pred_valid_o = 0. The third lookup cycle after the update returns pred_valid_o = 1.
- R9: Lookup results appear on the outputs on the clock edge after the request. pred_valid_o is 0 in any cycle that follows a cycle without fetch_req_i.
- R10: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Lookup request |
| fetch_idx_i | input | 10 | Cache line index being fetched |
| fetch_pf_i | input | 1 | Fetch is served from the prefetch path |
| upd_i | input | 1 | A mispredicted branch has resolved |
| upd_idx_i | input | 10 | Line index of the mispredicted branch |
| upd_cacheable_i | input | 1 | The branch came from a cacheable fetch |
| upd_ofs_i | input | 4 | New end offset within the line |
| upd_taken_i | input | 1 | Resolved direction |
| upd_succ_i | input | 10 | Cache index of the resolved target line |
| inval_i | input | 1 | Clear all predictions |
| pred_valid_o | output | 1 | The lookup result is usable |
| pred_taken_o | output | 1 | Line predicted to exit through a taken branch |
| end_ofs_o | output | 4 | Last byte offset of the fetch window |
| next_idx_o | output | 10 | Index of the next line to fetch |

## Verification
The lookup path is exercised with four kinds of line: never-written lines, taken entries, entries rewritten to not-taken, and lines at the top index where the sequential successor wraps. These separate stored-successor selection from fall-through selection. Prefetch-path lookups of a line that holds a taken entry show whether that flag overrides the stored entry. Non-cacheable updates, and updates that coincide with an invalidate, show the write gating. A lookup of the same line in the same cycle as its update shows read-before-write ordering. Lookups placed in each cycle after a mispredict show where the redirect window starts and ends.

// File: rtl/lnp_pkg.sv
package lnp_pkg;
  parameter int unsigned LINES   = 1024;
  parameter int unsigned LINE_B  = 16;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned OFS_W  = $clog2(LINE_B);

  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic             taken;
    logic [IDX_W-1:0] succ;
  } entry_t;
endpackage

// File: rtl/lnp_store.sv
module lnp_store
  import lnp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_ent_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_hit_o,
  output entry_t           rd_ent_o
);
  logic [LINES-1:0] vld_q;
  entry_t           mem_q [LINES];

  // valid bits carry the bulk clear; data array needs no reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem_q[wr_idx_i] <= wr_ent_i;
  end

  assign rd_hit_o = vld_q[rd_idx_i];
  assign rd_ent_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lnp_redirect.sv
module lnp_redirect #(
  parameter int unsigned CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mispred_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (mispred_i)    cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // window covers the mispredict cycle and CYC-1 after it
  assign busy_o = mispred_i || (cnt_q != '0);
endmodule

// File: rtl/lnp_select.sv
module lnp_select
  import lnp_pkg::*;
(
  input  logic             hit_i,
  input  entry_t           ent_i,
  input  logic             pf_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             taken_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [IDX_W-1:0] next_o
);
  logic [IDX_W-1:0] seq;

  assign seq = (idx_i == IDX_W'(LINES - 1)) ? '0 : idx_i + 1'b1;

  always_comb begin
    taken_o = hit_i && ent_i.taken && !pf_i;
    ofs_o   = taken_o ? ent_i.ofs  : '1;
    next_o  = taken_o ? ent_i.succ : seq;
  end
endmodule

// File: rtl/line_next_predictor.sv
module line_next_predictor
  import lnp_pkg::*;
#(
  parameter int unsigned REDIRECT_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_req_i,
  input  logic [IDX_W-1:0] fetch_idx_i,
  input  logic             fetch_pf_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_cacheable_i,
  input  logic [OFS_W-1:0] upd_ofs_i,
  input  logic             upd_taken_i,
  input  logic [IDX_W-1:0] upd_succ_i,
  input  logic             inval_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [OFS_W-1:0] end_ofs_o,
  output logic [IDX_W-1:0] next_idx_o
);
  logic             rd_hit, busy, sel_taken;
  entry_t           rd_ent, wr_ent;
  logic [OFS_W-1:0] sel_ofs;
  logic [IDX_W-1:0] sel_next;

  assign wr_ent = '{ofs: upd_ofs_i, taken: upd_taken_i, succ: upd_succ_i};

  lnp_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (upd_i && upd_cacheable_i),
    .wr_idx_i (upd_idx_i),
    .wr_ent_i (wr_ent),
    .clr_i    (inval_i),
    .rd_idx_i (fetch_idx_i),
    .rd_hit_o (rd_hit),
    .rd_ent_o (rd_ent)
  );

  lnp_redirect #(.CYC(REDIRECT_CYC)) u_redirect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mispred_i (upd_i),
    .busy_o    (busy)
  );

  lnp_select u_select (
    .hit_i   (rd_hit),
    .ent_i   (rd_ent),
    .pf_i    (fetch_pf_i),
    .idx_i   (fetch_idx_i),
    .taken_o (sel_taken),
    .ofs_o   (sel_ofs),
    .next_o  (sel_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
      end_ofs_o    <= '0;
      next_idx_o   <= '0;
    end else begin
      pred_valid_o <= fetch_req_i && !busy;
      if (fetch_req_i) begin
        pred_taken_o <= sel_taken;
        end_ofs_o    <= sel_ofs;
        next_idx_o   <= sel_next;
      end
    end
  end
endmodule

// File: rtl/lnp_checker.sv
module lnp_checker
  import lnp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req_i,
  input logic [IDX_W-1:0] fetch_idx_i,
  input logic             fetch_pf_i,
  input logic             upd_i,
  input logic             inval_i,
  input logic             pred_valid_o,
  input logic             pred_taken_o,
  input logic [OFS_W-1:0] end_ofs_o,
  input logic [IDX_W-1:0] next_idx_o
);
  a_r9_no_req_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |=> !pred_valid_o);

  a_r8_mispred_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !pred_valid_o);

  a_r5_prefetch_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && fetch_pf_i) |=>
      (!pred_taken_o && end_ofs_o == '1 &&
       next_idx_o == (($past(fetch_idx_i) == IDX_W'(LINES - 1)) ? '0 : $past(fetch_idx_i) + 1'b1)));

  a_r7_inval_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i ##1 fetch_req_i |=> !pred_taken_o);

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!pred_valid_o && !pred_taken_o));
endmodule

bind line_next_predictor lnp_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_req_i  (fetch_req_i),
  .fetch_idx_i  (fetch_idx_i),
  .fetch_pf_i   (fetch_pf_i),
  .upd_i        (upd_i),
  .inval_i      (inval_i),
  .pred_valid_o (pred_valid_o),
  .pred_taken_o (pred_taken_o),
  .end_ofs_o    (end_ofs_o),
  .next_idx_o   (next_idx_o)
);

// File: tb/tb_line_next_predictor.sv
module tb_line_next_predictor;
  import lnp_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             fetch_req_i = 1'b0, fetch_pf_i = 1'b0;
  logic [IDX_W-1:0] fetch_idx_i = '0;
  logic             upd_i = 1'b0, upd_cacheable_i = 1'b0, upd_taken_i = 1'b0, inval_i = 1'b0;
  logic [IDX_W-1:0] upd_idx_i = '0, upd_succ_i = '0;
  logic [OFS_W-1:0] upd_ofs_i = '0;
  logic             pred_valid_o, pred_taken_o;
  logic [OFS_W-1:0] end_ofs_o;
  logic [IDX_W-1:0] next_idx_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  line_next_predictor dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // kind: 0 lookup only, 1 update then lookup
  typedef struct packed {
    logic [1:0]  kind;
    logic        cach;
    logic [9:0]  idx;
    logic [3:0]  ofs;
    logic        tk;
    logic [9:0]  succ;
    logic        pf;
    logic        e_tk;
    logic [3:0]  e_ofs;
    logic [9:0]  e_next;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 10'd5,    4'd0,  1'b0, 10'd0,    1'b0, 1'b0, 4'd15, 10'd6,    8'd1},
    '{2'd1, 1'b1, 10'd5,    4'd9,  1'b1, 10'd300,  1'b0, 1'b1, 4'd9,  10'd300,  8'd2},
    '{2'd1, 1'b0, 10'd7,    4'd3,  1'b1, 10'd20,   1'b0, 1'b0, 4'd15, 10'd8,    8'd4},
    '{2'd0, 1'b0, 10'd1023, 4'd0,  1'b0, 10'd0,    1'b0, 1'b0, 4'd15, 10'd0,    8'd1},
    '{2'd1, 1'b1, 10'd5,    4'd4,  1'b0, 10'd11,   1'b0, 1'b0, 4'd15, 10'd6,    8'd3},
    '{2'd1, 1'b1, 10'd1023, 4'd15, 1'b1, 10'd0,    1'b0, 1'b1, 4'd15, 10'd0,    8'd2},
    '{2'd0, 1'b0, 10'd1023, 4'd0,  1'b0, 10'd0,    1'b1, 1'b0, 4'd15, 10'd0,    8'd5},
    '{2'd1, 1'b1, 10'd200,  4'd0,  1'b1, 10'd1023, 1'b0, 1'b1, 4'd0,  10'd1023, 8'd2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic idle();
    fetch_req_i = 0; fetch_pf_i = 0; upd_i = 0; inval_i = 0;
  endtask

  task automatic drive_upd(input logic c, input logic [9:0] i, input logic [3:0] o,
                           input logic t, input logic [9:0] s);
    upd_i = 1; upd_cacheable_i = c; upd_idx_i = i; upd_ofs_i = o; upd_taken_i = t; upd_succ_i = s;
  endtask

  task automatic lookup(input logic [9:0] i, input logic pf);
    fetch_req_i = 1; fetch_idx_i = i; fetch_pf_i = pf;
    tick();
    idle();
  endtask

  task automatic chk_out(input string req, input logic v, input logic t,
                         input logic [3:0] o, input logic [9:0] n);
    chk(req, "valid", int'(pred_valid_o), int'(v));
    chk(req, "taken", int'(pred_taken_o), int'(t));
    chk(req, "end_ofs", int'(end_ofs_o), int'(o));
    chk(req, "next_idx", int'(next_idx_o), int'(n));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R10: outputs during reset
    chk_out("R10", 0, 0, 4'd0, 10'd0);
    rst_ni = 1;
    tick();

    // table walk: R1 R2 R4 R3 R5
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].kind == 2'd1) begin
        drive_upd(VECS[k].cach, VECS[k].idx, VECS[k].ofs, VECS[k].tk, VECS[k].succ);
        tick(); idle(); tick(); tick();
      end
      lookup(VECS[k].idx, VECS[k].pf);
      chk_out($sformatf("R%0d", VECS[k].req), 1, VECS[k].e_tk, VECS[k].e_ofs, VECS[k].e_next);
    end

    // R9: no request, no valid
    tick();
    chk("R9", "valid idle", int'(pred_valid_o), 0);

    // R8: redirect window, lookups in update cycle and the three after
    drive_upd(1, 10'd40, 4'd2, 1, 10'd41);
    fetch_req_i = 1; fetch_idx_i = 10'd40;
    tick(); upd_i = 0;
    chk("R8", "valid cyc0", int'(pred_valid_o), 0);
    tick(); chk("R8", "valid cyc1", int'(pred_valid_o), 0);
    tick(); chk("R8", "valid cyc2", int'(pred_valid_o), 0);
    tick(); chk("R8", "valid cyc3", int'(pred_valid_o), 1);
    chk("R2", "taken after window", int'(pred_taken_o), 1);
    idle(); tick(); tick();

    // R6: same-cycle update and lookup of line 40 (old: taken, succ 41)
    drive_upd(1, 10'd40, 4'd7, 1, 10'd500);
    fetch_req_i = 1; fetch_idx_i = 10'd40;
    tick(); upd_i = 0; fetch_req_i = 0;
    chk("R6", "old succ", int'(next_idx_o), 41);
    chk("R6", "old ofs", int'(end_ofs_o), 2);
    tick(); tick();
    lookup(10'd40, 0);
    chk_out("R6", 1, 1, 4'd7, 10'd500);

    // R7: invalidate clears all lines
    inval_i = 1; tick(); idle();
    lookup(10'd200, 0);
    chk_out("R7", 1, 0, 4'd15, 10'd201);
    lookup(10'd40, 0);
    chk_out("R7", 1, 0, 4'd15, 10'd41);

    // R7: invalidate beats a simultaneous update
    drive_upd(1, 10'd50, 4'd1, 1, 10'd99);
    inval_i = 1;
    tick(); idle(); tick(); tick();
    lookup(10'd50, 0);
    chk_out("R7", 1, 0, 4'd15, 10'd51);

    // R5: prefetch path overrides a taken entry
    drive_upd(1, 10'd60, 4'd3, 1, 10'd70);
    tick(); idle(); tick(); tick();
    lookup(10'd60, 1);
    chk_out("R5", 1, 0, 4'd15, 10'd61);
    lookup(10'd60, 0);
    chk_out("R2", 1, 1, 4'd3, 10'd70);

    // R4: non-cacheable update leaves the taken entry intact
    drive_upd(0, 10'd60, 4'd9, 0, 10'd1);
    tick(); idle(); tick(); tick();
    lookup(10'd60, 0);
    chk_out("R4", 1, 1, 4'd3, 10'd70);

    // R10: reset mid-run
    rst_ni = 0; #1;
    chk_out("R10", 0, 0, 4'd0, 10'd0);
    tick(); rst_ni = 1; tick();
    lookup(10'd60, 0);
    chk_out("R1", 1, 0, 4'd15, 10'd61);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule